// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a simple clocked request/acknowledge port to an external, unclocked static RAM that holds 4096 one-bit words. The RAM has a 12-bit address, one input data pin, one output data pin, and two active-low strobes: chip select and write strobe. The controller turns each host request into a fixed sequence of strobe phases. The address and write data are driven before any strobe falls and stay unchanged until both strobes are high again. For reads, the controller waits out the full access time before it latches the RAM output.

Each phase length is a parameter counted in clock cycles. The integrator picks it as the ceiling of the RAM's nanosecond minimum divided by the clock period. The phases are address setup, write pulse, read access wait and release/hold. Between requests the RAM is kept in standby with both strobes high. Requests are taken only while the controller is idle. Completion is signalled by a one-cycle acknowledge, and read data is valid from that point until the next read finishes.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `ram_cs_n` and `ram_wr_n` are 1, `ack` is 0, `rdata` is 0 and `ram_addr` is 0.
- R2: While no request is being served, `ram_cs_n` and `ram_wr_n` are both 1 (standby).
- R3: After a request is accepted, the new address sits on `ram_addr` with both strobes high for exactly SETUP_CYC cycles before `ram_cs_n` falls. The address does not change on the edge where `ram_cs_n` falls.
- R4: A write (`we`=1) holds `ram_cs_n` and `ram_wr_n` both at 0 for exactly PULSE_CYC cycles. `ram_wr_n` is never 0 while `ram_cs_n` is 1, so the write strobe is released no later than chip select.
- R5: `ram_addr` and `ram_din` do not change in the cycle that follows any cycle with `ram_cs_n` at 0, so they stay stable through the strobe phase and the release cycle after it.
- R6: A read (`we`=0) holds `ram_cs_n` at 0 and `ram_wr_n` at 1 for exactly ACCESS_CYC cycles. `ram_dout` is sampled on the last clock edge of that window, and the value appears on `rdata` together with `ack`.
- R7: `rdata` changes only at the end of a read. Writes and standby leave it unchanged, whatever `ram_dout` shows meanwhile.
- R8: `ack` is a one-cycle pulse. It rises SETUP_CYC + (PULSE_CYC or ACCESS_CYC) + HOLD_CYC clock edges after the edge that accepted the request, the last HOLD_CYC of those edges being spent with both strobes high.
- R9: A `req` seen while a request is in progress is ignored: it produces no extra `ack` and no RAM write.
- R10: A write stores `wdata` at `addr`, and a later read of the same address returns it on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Word address |
| wdata | input | 1 | Write data |
| rdata | output | 1 | Data from the last completed read |
| ack | output | 1 | One-cycle completion pulse |
| ram_addr | output | 12 | Registered address to the RAM |
| ram_din | output | 1 | Registered data to the RAM input pin |
| ram_dout | input | 1 | RAM output pin |
| ram_cs_n | output | 1 | Active-low chip select, registered |
| ram_wr_n | output | 1 | Active-low write strobe, registered |

## Verification
The hardest situation to reach from the ports is a controller that samples the RAM output too early, because a real RAM still drives its old data, or floats, during the access window. The bench's RAM model therefore drives the complement of the stored bit until chip select has been low for the full ACCESS_CYC cycles, and drives a toggling junk value while writing or in standby. An early capture then returns wrong data, and a write that leaks into `rdata` is caught. A second `req` pulse in the middle of a write, carrying a different address, checks that busy-time requests leave no trace in the memory.

// File: rtl/sram_seq_pkg.sv
// Shared types for the asynchronous SRAM access controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_seq_pkg;

    // Controller phases; strobe phase covers both write pulse and read access
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    // Largest of four phase lengths, used to size the phase counter
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down counter that times one controller phase.
// A load sets the count to the phase length; `last` is high in the final
// cycle of the phase. Assumes every loaded length is at least 1.
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Load a new phase length or count the current phase down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CW'(1));

    AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R3

    AST_TIMER_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !last); // R8

endmodule

// File: rtl/sram_rd_capture.sv
// Read-data register: samples the RAM output pin only when enabled.
// Assumes the enable is high only on the final edge of a read access window.
module sram_rd_capture #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    // Hold the last captured read value between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap_en) begin
            q <= d;
        end
    end

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(q)); // R7

endmodule

// File: rtl/sram_seq_ctrl.sv
// Asynchronous SRAM access controller (top).
// Turns one host request into setup, strobe and release phases on a
// 4K x 1 static RAM with separate data pins. All RAM-side outputs come
// straight from registers. Assumes every phase parameter is >= 1, chosen
// as ceil(ns_min / clock_period), and that the host holds addr/we/wdata
// valid only in the cycle where req is seen while idle.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 1,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int ACCESS_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ack,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_din,
    input  logic [DW-1:0] ram_dout,
    output logic          ram_cs_n,
    output logic          ram_wr_n
);

    localparam int MAXC = max4(SETUP_CYC, PULSE_CYC, ACCESS_CYC, HOLD_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state_q, state_d;
    logic          op_wr_q;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_last;
    logic          cap_en;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req;

    // Phase sequencing: pick the next phase and the length to load
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = CW'(SETUP_CYC);
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_SETUP;
                    t_load  = 1'b1;
                    t_val   = CW'(SETUP_CYC);
                end
            end
            ST_SETUP: begin
                if (t_last) begin
                    state_d = ST_STROBE;
                    t_load  = 1'b1;
                    t_val   = op_wr_q ? CW'(PULSE_CYC) : CW'(ACCESS_CYC);
                end
            end
            ST_STROBE: begin
                if (t_last) begin
                    state_d = ST_HOLD;
                    t_load  = 1'b1;
                    t_val   = CW'(HOLD_CYC);
                end
            end
            ST_HOLD: begin
                if (t_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cap_en = (state_q == ST_STROBE) && t_last && !op_wr_q;

    // State, strobes and completion pulse, all registered from the next phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ram_cs_n <= 1'b1;
            ram_wr_n <= 1'b1;
            ack      <= 1'b0;
        end else begin
            state_q  <= state_d;
            ram_cs_n <= (state_d != ST_STROBE);
            ram_wr_n <= !((state_d == ST_STROBE) && op_wr_q);
            ack      <= (state_q == ST_HOLD) && t_last;
        end
    end

    // Request latch: address, data and direction are frozen at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= '0;
            ram_din  <= '0;
            op_wr_q  <= 1'b0;
        end else if (accept) begin
            ram_addr <= addr;
            ram_din  <= wdata;
            op_wr_q  <= we;
        end
    end

    sram_phase_timer #(
        .CW(CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .last    (t_last)
    );

    sram_rd_capture #(
        .DW(DW)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cap_en),
        .d     (ram_dout),
        .q     (rdata)
    );

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (ram_cs_n && ram_wr_n)); // R2

    AST_CS_FALL_ADDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_cs_n) |-> $stable(ram_addr)); // R3

    AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n |-> !ram_cs_n); // R4

    AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |=> ($stable(ram_addr) && $stable(ram_din))); // R5

    AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (!ram_cs_n && ram_wr_n)); // R6

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8

    AST_ACK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(ram_cs_n) && $past(ram_wr_n))); // R8

endmodule

// File: tb/sim_sram_seq_ctrl.sv
// Bench: exhaustive write/read sweep over all 4096 words through a
// behavioural RAM model that only shows valid data after the access window.
module sim_sram_seq_ctrl;

    localparam int S  = 1;
    localparam int P  = 2;
    localparam int A  = 2;
    localparam int H  = 1;
    localparam int AW = 12;
    localparam int NW = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wdata = 1'b0;
    logic          rdata;
    logic          ack;
    logic [AW-1:0] ram_addr;
    logic          ram_din;
    logic          ram_dout;
    logic          ram_cs_n;
    logic          ram_wr_n;

    int n_run  = 0;
    int n_fail = 0;
    int n_ack  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sram_seq_ctrl #(
        .AW(AW), .DW(1), .SETUP_CYC(S), .PULSE_CYC(P),
        .ACCESS_CYC(A), .HOLD_CYC(H)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .ram_addr(ram_addr),
        .ram_din(ram_din), .ram_dout(ram_dout), .ram_cs_n(ram_cs_n),
        .ram_wr_n(ram_wr_n)
    );

    // ---------------- RAM model ----------------
    logic          mem [NW];
    int            low_cnt = 0;
    logic          junk = 1'b0;
    bit            was_wr = 1'b0;
    logic [AW-1:0] wr_a = '0;
    logic          wr_d = 1'b0;
    logic [AW-1:0] cs_a = '0;
    logic          cs_d = 1'b0;

    assign ram_dout = (!ram_cs_n && ram_wr_n)
                      ? ((low_cnt >= A) ? mem[ram_addr] : ~mem[ram_addr])
                      : junk;

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    // Model: count access window, commit writes at strobe release, check pin stability
    always @(negedge clk) begin
        junk <= ~junk;
        if (!ram_cs_n) begin
            if (low_cnt == 0) begin
                cs_a = ram_addr;
                cs_d = ram_din;
            end else begin
                check(ram_addr == cs_a, "R5 addr", int'(ram_addr), int'(cs_a));
                check(ram_din == cs_d, "R5 din", int'(ram_din), int'(cs_d));
            end
            low_cnt <= low_cnt + 1;
        end else begin
            if (low_cnt != 0) begin
                check(ram_addr == cs_a, "R5 release addr", int'(ram_addr), int'(cs_a));
            end
            low_cnt <= 0;
        end
        if (was_wr && !(!ram_cs_n && !ram_wr_n)) mem[wr_a] = wr_d;
        was_wr = !ram_cs_n && !ram_wr_n;
        wr_a   = ram_addr;
        wr_d   = ram_din;
        if (ack) n_ack++;
    end

    function automatic logic pat(input int a, input int salt);
        logic [15:0] v;
        v = 16'(a * 37 + salt);
        return ^v;
    endfunction

    // One host transaction with timing measurement at negedges
    task automatic op(input logic w, input logic [AW-1:0] a, input logic d,
                      input bit chk_t, output logic q);
        int lat, first_low, cs_cnt, wr_cnt, xlen;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        lat = 0; first_low = 0; cs_cnt = 0; wr_cnt = 0;
        do begin
            @(negedge clk);
            req = 1'b0;
            lat++;
            if (!ram_cs_n) begin
                cs_cnt++;
                if (first_low == 0) first_low = lat;
            end
            if (!ram_wr_n) wr_cnt++;
            if (lat == 1) check(ram_addr == a, "R3 addr driven", int'(ram_addr), int'(a));
        end while (!ack && lat < 60);
        q = rdata;
        xlen = w ? P : A;
        if (chk_t) begin
            check(lat == S + xlen + H + 1, "R8 latency", lat, S + xlen + H + 1);
            check(first_low == S + 1, "R3 setup", first_low, S + 1);
            if (w) begin
                check(cs_cnt == P, "R4 pulse cs", cs_cnt, P);
                check(wr_cnt == P, "R4 pulse wr", wr_cnt, P);
            end else begin
                check(cs_cnt == A, "R6 access", cs_cnt, A);
                check(wr_cnt == 0, "R6 wr high", wr_cnt, 0);
            end
        end
        @(negedge clk);
        if (chk_t) begin
            check(ack == 1'b0, "R8 one cycle", int'(ack), 0);
            check(ram_cs_n && ram_wr_n, "R2 standby", int'({ram_cs_n, ram_wr_n}), 3);
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic q;
        logic v;
        int   acks0;
        for (int i = 0; i < NW; i++) mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ram_cs_n == 1'b1, "R1 cs_n", int'(ram_cs_n), 1);
        check(ram_wr_n == 1'b1, "R1 wr_n", int'(ram_wr_n), 1);
        check(ack == 1'b0, "R1 ack", int'(ack), 0);
        check(rdata == 1'b0, "R1 rdata", int'(rdata), 0);
        check(ram_addr == '0, "R1 addr", int'(ram_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ram_cs_n && ram_wr_n, "R2 idle", int'({ram_cs_n, ram_wr_n}), 3);

        // R10: exhaustive write then read sweep
        for (int i = 0; i < NW; i++) op(1'b1, AW'(i), pat(i, 5), (i < 16) || (i == NW - 1), q);
        for (int i = 0; i < NW; i++) begin
            op(1'b0, AW'(i), 1'b0, (i < 16) || (i == NW - 1), q);
            check(q == pat(i, 5), "R10 R6 readback", int'(q), int'(pat(i, 5)));
        end
        // Second pass, inverted pattern on a corner range
        for (int i = NW - 64; i < NW; i++) op(1'b1, AW'(i), ~pat(i, 5), 1'b0, q);
        for (int i = NW - 64; i < NW; i++) begin
            op(1'b0, AW'(i), 1'b0, 1'b0, q);
            check(q == ~pat(i, 5), "R10 rewrite", int'(q), int'(~pat(i, 5)));
        end

        // R7: writes leave rdata untouched
        op(1'b0, 12'd100, 1'b0, 1'b1, q);
        v = q;
        for (int k = 0; k < 4; k++) begin
            op(1'b1, AW'(200 + k), ~v, 1'b1, q);
            check(q == v, "R7 rdata kept over write", int'(q), int'(v));
        end
        repeat (5) @(negedge clk);
        check(rdata == v, "R7 rdata kept in standby", int'(rdata), int'(v));

        // R9: request during a busy write is ignored
        op(1'b0, 12'd300, 1'b0, 1'b0, q);
        v = q;
        acks0 = n_ack;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 12'd301; wdata = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 12'd300; wdata = ~v;
        @(negedge clk);
        req = 1'b0;
        repeat (12) @(negedge clk);
        check(n_ack - acks0 == 1, "R9 single ack", n_ack - acks0, 1);
        op(1'b0, 12'd300, 1'b0, 1'b1, q);
        check(q == v, "R9 busy req not written", int'(q), int'(v));
        op(1'b0, 12'd301, 1'b0, 1'b1, q);
        check(q == 1'b1, "R9 first req written", int'(q), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule